// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block drives an external analog-to-digital converter core through two phases for every conversion: a sample-and-hold window, then the conversion itself. It holds a bank of sixteen slots. Each slot has a control word (input channel, reference select, end-of-sequence flag) and a 12-bit result register. A run starts at a programmable slot. Every result is written into the result register of the slot that requested it.

Four run modes are available: one slot once, a sequence once, one slot repeatedly, and a sequence repeatedly. A sequence walks consecutive slots and wraps from 15 to 0. It stops after the first slot whose end-of-sequence flag is set. The start event comes from one of four selectable trigger sources. The sample window is either timed by a programmed code (pulse timing) or follows the high time of the trigger (extended timing). A single write port programs the slot words and the configuration. Results are read back through a combinational read port.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `sample_hold` and `conv_go` are low and every result register reads zero.
- R2: Write address 0..15 loads the slot word, with channel in bits [3:0], reference select in bits [6:4] and end-of-sequence in bit 7. Address 16 loads the configuration: bit 0 module-on, bit 1 enable, bit 2 auto-continue, bit 3 pulse timing (0 = extended), bits [7:4] sample code, bits [11:8] start slot, bits [13:12] mode (0 single, 1 sequence, 2 repeat single, 3 repeat sequence) and bits [15:14] trigger select. Address 17 bit 0 is the software start level. While a slot is converting, `conv_chan` and `conv_ref` show that slot's fields.
- R3: In single mode, only the start slot is converted and written, once per trigger.
- R4: In sequence mode, slots are converted in ascending order from the start slot, wrapping 15 to 0, through the first slot flagged end-of-sequence. Each result lands in its own slot.
- R5: With auto-continue set, each following conversion of a sequence or repeat run starts with no new trigger. With it clear, each step waits for a fresh trigger rising edge while `busy` stays high.
- R6: Repeat modes restart at the start slot after each completed sequence while enable is set. Clearing enable lets the current sequence finish and then stops.
- R7: In pulse timing, a trigger rising edge starts a sample window of 4, 8, 16, 32, 64, 96, 128, 192, 256, 384, 512 or 768 cycles for codes 0..11, and 1024 cycles for codes 12..15. Auto-continued samples always use this timed length.
- R8: In extended timing, the sample window begins at the trigger rising edge and lasts as many cycles as the trigger stays high.
- R9: Trigger select 0 uses the software start bit, and selects 1..3 use `tmr_trig[0]`..`tmr_trig[2]`. Edges on unselected sources are ignored.
- R10: A run starts only when module-on and enable are both set. Clearing module-on aborts any run at once, with no conversion and no write.
- R11: `busy` rises when a trigger is accepted and falls in the cycle the final result is written.
- R12: `conv_go` is raised only after a sample window and held until `conv_done`. The result is then taken from `conv_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| tmr_trig | input | 3 | Timer trigger sources |
| conv_done | input | 1 | Converter result valid |
| conv_code | input | 12 | Converter result code |
| rd_slot | input | 4 | Result read slot |
| sample_hold | output | 1 | Sample-and-hold window active |
| conv_go | output | 1 | Conversion phase active |
| conv_chan | output | 4 | Channel of the active slot |
| conv_ref | output | 3 | Reference select of the active slot |
| busy | output | 1 | Run in progress |
| rd_data | output | 12 | Result of slot `rd_slot` |

## Verification
The hardest state to reach is a repeat run that is stopped part-way through a sequence. The enable bit must fall while a middle slot is converting, and the block must still finish that sequence and not halt at once. The bench waits until the converter stub has logged a set number of conversions in a three-slot repeat sequence, so the run is mid-sequence. It then clears enable and checks that the total count is a whole multiple of the sequence length, in slot order. A second hard case is a wrapped sequence from slot 14 through slot 1. The bench reaches it by placing the only end-of-sequence flag below the start slot.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SLOT_W = 4;
  localparam int CODE_W = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV, ST_WAIT} seq_state_e;

  typedef struct packed {
    logic [1:0]        trig_sel;
    logic [1:0]        mode;
    logic [SLOT_W-1:0] start;
    logic [3:0]        sht;
    logic              pulse;
    logic              msc;
    logic              enc;
    logic              on;
  } cfg_t;

  typedef struct packed {
    logic       eos;
    logic [2:0] refsel;
    logic [3:0] chan;
  } slot_word_t;

  // Sample window length in cycles for a 4-bit timing code.
  function automatic logic [10:0] sample_cycles(input logic [3:0] code);
    logic [10:0] base;
    if (code < 4'd4)       sample_cycles = 11'd4 << code;
    else if (code < 4'd12) begin
      base = code[0] ? 11'd96 : 11'd64;
      sample_cycles = base << ((code - 4'd4) >> 1);
    end
    else                   sample_cycles = 11'd1024;
  endfunction
endpackage

// File: rtl/adc_seq_regbank.sv
module adc_seq_regbank
  import adc_seq_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int ADDR_W = $clog2(NSLOT) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [15:0]                   cfg_wdata,
  input  logic                          res_we,
  input  logic [SLOT_W-1:0]             res_slot,
  input  logic [CODE_W-1:0]             res_data,
  input  logic [SLOT_W-1:0]             rd_slot,
  output cfg_t                          cfg,
  output logic                          sc,
  output slot_word_t [NSLOT-1:0]        words,
  output logic [CODE_W-1:0]             rd_data
);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NSLOT);
  localparam logic [ADDR_W-1:0] SC_ADDR  = ADDR_W'(NSLOT + 1);

  logic [CODE_W-1:0] res_q [NSLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      sc  <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_ADDR) cfg <= cfg_t'(cfg_wdata);
      if (cfg_addr == SC_ADDR)  sc  <= cfg_wdata[0];
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic word_en, res_en;
    assign word_en = cfg_we && (cfg_addr == ADDR_W'(i));
    assign res_en  = res_we && (res_slot == SLOT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       words[i] <= '0;
      else if (word_en) words[i] <= slot_word_t'(cfg_wdata[7:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q[i] <= '0;
      else if (res_en) res_q[i] <= res_data;
    end
  end

  assign rd_data = res_q[rd_slot];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W:0]   len,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = CNT_W'(len - 1'b1);
    else if (run && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  assert_timer_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run && !load && cnt_q != '0) && !$past(load)) |-> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int NTRIG = 4,
  localparam int TSEL_W = $clog2(NTRIG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on,
  input  logic              enc,
  input  logic              msc,
  input  logic              pulse,
  input  logic [1:0]        mode,
  input  logic [SLOT_W-1:0] start,
  input  logic [TSEL_W-1:0] trig_sel,
  input  logic [NTRIG-1:0]  trig_vec,
  input  logic [NSLOT-1:0]  eos_vec,
  input  logic              conv_done,
  input  logic              tmr_expired,
  output logic              busy,
  output logic              sample_hold,
  output logic              conv_go,
  output logic [SLOT_W-1:0] slot,
  output logic              tmr_load,
  output logic              res_we
);
  seq_state_e state_q, state_d;
  logic [SLOT_W-1:0] slot_d;
  logic trig_q, timed_q, timed_d;
  logic trig, trig_edge, last_step, go_on;

  assign trig      = trig_vec[trig_sel];
  assign trig_edge = trig && !trig_q;
  // mode[0]: many slots; mode[1]: repeat
  assign last_step = !mode[0] || eos_vec[slot];

  always_comb begin
    state_d  = state_q;
    slot_d   = slot;
    timed_d  = timed_q;
    res_we   = 1'b0;
    go_on    = 1'b0;
    case (state_q)
      ST_IDLE: if (on && enc && trig_edge) begin
        state_d = ST_SAMPLE;
        slot_d  = start;
        timed_d = pulse;
      end
      ST_SAMPLE: if (timed_q ? tmr_expired : !trig) state_d = ST_CONV;
      ST_CONV: if (conv_done) begin
        res_we = 1'b1;
        if (!last_step) begin
          slot_d = slot + 1'b1;
          go_on  = 1'b1;
        end else if (mode[1] && enc) begin
          slot_d = start;
          go_on  = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
        if (go_on) begin
          state_d = msc ? ST_SAMPLE : ST_WAIT;
          timed_d = 1'b1;
        end
      end
      ST_WAIT: if (trig_edge) begin
        state_d = ST_SAMPLE;
        timed_d = pulse;
      end
      default: state_d = ST_IDLE;
    endcase
    if (!on) begin
      state_d = ST_IDLE;
      res_we  = 1'b0;
    end
  end

  assign tmr_load = (state_d == ST_SAMPLE) && (state_q != ST_SAMPLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot    <= '0;
      trig_q  <= 1'b0;
      timed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      slot    <= slot_d;
      trig_q  <= trig;
      timed_q <= timed_d;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign sample_hold = (state_q == ST_SAMPLE);
  assign conv_go     = (state_q == ST_CONV);

  assert_start_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(on && enc));
  assert_conv_after_sample_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_go) |-> $past(sample_hold));
  assert_single_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_go && conv_done && mode == 2'b00) |=> !busy);
  assert_busy_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(conv_go && conv_done) || !$past(on)));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int NTMR   = 3,
  localparam int ADDR_W = $clog2(NSLOT) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic [NTMR-1:0]   tmr_trig,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              sample_hold,
  output logic              conv_go,
  output logic [3:0]        conv_chan,
  output logic [2:0]        conv_ref,
  output logic              busy,
  output logic [CODE_W-1:0] rd_data
);
  cfg_t                   cfg;
  logic                   sc, res_we, tmr_load, tmr_expired;
  slot_word_t [NSLOT-1:0] words;
  logic [NSLOT-1:0]       eos_vec;
  logic [SLOT_W-1:0]      slot;

  for (genvar i = 0; i < NSLOT; i++) begin : g_eos
    assign eos_vec[i] = words[i].eos;
  end

  adc_seq_regbank #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .res_we, .res_slot(slot), .res_data(conv_code), .rd_slot,
    .cfg, .sc, .words, .rd_data
  );

  adc_seq_timer #(.CNT_W(10)) u_timer (
    .clk, .rst_n, .load(tmr_load), .run(sample_hold),
    .len(sample_cycles(cfg.sht)), .expired(tmr_expired)
  );

  adc_seq_fsm #(.NSLOT(NSLOT), .NTRIG(NTMR + 1)) u_fsm (
    .clk, .rst_n, .on(cfg.on), .enc(cfg.enc), .msc(cfg.msc), .pulse(cfg.pulse),
    .mode(cfg.mode), .start(cfg.start), .trig_sel(cfg.trig_sel),
    .trig_vec({tmr_trig, sc}), .eos_vec, .conv_done, .tmr_expired,
    .busy, .sample_hold, .conv_go, .slot, .tmr_load, .res_we
  );

  assign conv_chan = words[slot].chan;
  assign conv_ref  = words[slot].refsel;
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int LAT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [2:0] tmr_trig = '0;
  logic conv_done;
  logic [11:0] conv_code;
  logic [3:0] rd_slot = '0;
  logic sample_hold, conv_go, busy;
  logic [3:0] conv_chan;
  logic [2:0] conv_ref;
  logic [11:0] rd_data;

  int checks = 0, errors = 0;
  int nconv = 0, run_len = 0, last_len = 0;
  logic [3:0]  log_chan [1024];
  logic [11:0] log_code [1024];

  always #2.5 clk = ~clk;

  adc_seq_ctrl dut (.*);

  // converter stub
  logic [3:0] st_cnt;
  logic [4:0] st_num;
  always_ff @(posedge clk) begin
    if (!rst_n) begin st_cnt <= '0; st_num <= '0; end
    else begin
      st_cnt <= conv_go ? st_cnt + 1'b1 : '0;
      if (conv_done) st_num <= st_num + 1'b1;
    end
  end
  assign conv_done = conv_go && (st_cnt == 4'(LAT));
  assign conv_code = {conv_chan, conv_ref, st_num};

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (sample_hold) run_len++;
    else if (run_len != 0) begin last_len = run_len; run_len = 0; end
    if (conv_done && nconv < 1024) begin
      log_chan[nconv] = conv_chan;
      log_code[nconv] = conv_code;
      nconv++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int mkcfg(int on, int enc, int msc, int pls, int sht, int st, int md, int ts);
    return on | (enc << 1) | (msc << 2) | (pls << 3) | (sht << 4) | (st << 8) | (md << 12) | (ts << 14);
  endfunction

  function automatic int mkword(int eos, int rf, int ch);
    return ch | (rf << 4) | (eos << 7);
  endfunction

  function automatic int exp_len(int code);
    case (code)
      0: return 4;    1: return 8;    2: return 16;   3: return 32;
      4: return 64;   5: return 96;   6: return 128;  7: return 192;
      8: return 256;  9: return 384;  10: return 512; 11: return 768;
      default: return 1024;
    endcase
  endfunction

  task automatic soft_start();
    wr(17, 0);
    wr(17, 1);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic read_slot(input int s, output int v);
    @(negedge clk);
    rd_slot = 4'(s);
    #1 v = rd_data;
  endtask

  task automatic pulse_tmr(input int idx);
    @(negedge clk); tmr_trig[idx] = 1'b1;
    repeat (2) @(negedge clk); tmr_trig[idx] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, base, allz;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !sample_hold && !conv_go, "R1 outputs idle", int'(busy), 0);
    allz = 1;
    for (int s = 0; s < 16; s++) begin
      read_slot(s, v);
      if (v != 0) allz = 0;
    end
    check(allz == 1, "R1 results zero", allz, 1);

    // R3 R7 R2: single mode sweep over every timing code
    for (int c = 0; c < 16; c++) begin
      int s;
      s = (c * 5) % 16;
      wr(s, mkword(0, c % 8, 15 - c));
      wr(16, mkcfg(1, 1, 0, 1, c, s, 0, 0));
      base = nconv;
      soft_start();
      wait_idle();
      check(last_len == exp_len(c), "R7 pulse sample length", last_len, exp_len(c));
      check(nconv == base + 1, "R3 one conversion", nconv - base, 1);
      check(log_chan[base] == 4'(15 - c), "R2 channel presented", int'(log_chan[base]), 15 - c);
      read_slot(s, v);
      check(v == int'(log_code[base]), "R3 result in start slot", v, int'(log_code[base]));
      check(log_code[base][7:5] == 3'(c % 8), "R2 reference presented", int'(log_code[base][7:5]), c % 8);
    end

    // R4 R5: wrapped sequence 14,15,0,1 with auto-continue
    for (int s = 0; s < 16; s++) wr(s, mkword(s == 1, 1, s ^ 5));
    wr(16, mkcfg(1, 1, 1, 1, 0, 14, 1, 0));
    base = nconv;
    soft_start();
    wait_idle();
    check(nconv == base + 4, "R4 wrapped sequence length", nconv - base, 4);
    for (int k = 0; k < 4; k++) begin
      int s;
      s = (14 + k) % 16;
      check(log_chan[base + k] == 4'(s ^ 5), "R4 slot order", int'(log_chan[base + k]), s ^ 5);
      read_slot(s, v);
      check(v == int'(log_code[base + k]), "R4 result per slot", v, int'(log_code[base + k]));
    end

    // R5: no auto-continue, each step needs a trigger edge
    wr(6, mkword(0, 2, 6)); wr(7, mkword(1, 2, 7));
    wr(16, mkcfg(1, 1, 0, 1, 0, 6, 1, 0));
    base = nconv;
    soft_start();
    repeat (40) @(negedge clk);
    check(busy && nconv == base + 1, "R5 waits for trigger, busy held", nconv - base, 1);
    soft_start();
    wait_idle();
    check(nconv == base + 2 && log_chan[base + 1] == 4'd7, "R5 second step after trigger", nconv - base, 2);

    // R6: repeat single, stop via enable
    wr(9, mkword(0, 3, 3));
    wr(16, mkcfg(1, 1, 1, 1, 0, 9, 2, 0));
    base = nconv;
    soft_start();
    while (nconv < base + 3) @(negedge clk);
    wr(16, mkcfg(1, 0, 1, 1, 0, 9, 2, 0));
    wait_idle();
    v = nconv;
    repeat (50) @(negedge clk);
    check(nconv == v && !busy, "R6 repeat single stopped", nconv - v, 0);
    allz = 1;
    for (int k = base; k < nconv; k++) if (log_chan[k] != 4'd3) allz = 0;
    check(allz == 1, "R6 repeat single same slot", allz, 1);

    // R6: repeat sequence 3..5, enable cleared mid-sequence
    wr(3, mkword(0, 0, 10)); wr(4, mkword(0, 0, 11)); wr(5, mkword(1, 0, 12));
    wr(16, mkcfg(1, 1, 1, 1, 0, 3, 3, 0));
    base = nconv;
    soft_start();
    while (nconv < base + 4) @(negedge clk);
    wr(16, mkcfg(1, 0, 1, 1, 0, 3, 3, 0));
    wait_idle();
    check((nconv - base) % 3 == 0 && nconv - base >= 6, "R6 finishes current sequence", nconv - base, 6);
    allz = 1;
    for (int k = base; k < nconv; k++) if (log_chan[k] != 4'(10 + (k - base) % 3)) allz = 0;
    check(allz == 1, "R6 repeat sequence order", allz, 1);

    // R10: gating
    wr(16, mkcfg(1, 0, 0, 1, 0, 3, 0, 0));
    base = nconv;
    soft_start();
    repeat (40) @(negedge clk);
    check(!busy && nconv == base, "R10 enable clear blocks start", nconv - base, 0);
    wr(16, mkcfg(0, 1, 0, 1, 0, 3, 0, 0));
    soft_start();
    repeat (40) @(negedge clk);
    check(!busy && nconv == base, "R10 module off blocks start", nconv - base, 0);

    // R9: trigger select 2 -> tmr_trig[1]
    wr(16, mkcfg(1, 1, 0, 1, 0, 3, 0, 2));
    base = nconv;
    soft_start();
    pulse_tmr(0);
    pulse_tmr(2);
    repeat (30) @(negedge clk);
    check(nconv == base && !busy, "R9 unselected sources ignored", nconv - base, 0);
    pulse_tmr(1);
    wait_idle();
    check(nconv == base + 1, "R9 selected timer starts", nconv - base, 1);

    // R8 R11: extended timing via tmr_trig[2]
    wr(16, mkcfg(1, 1, 0, 0, 0, 4, 0, 3));
    base = nconv;
    @(negedge clk); tmr_trig[2] = 1'b1;
    repeat (37) @(negedge clk);
    tmr_trig[2] = 1'b0;
    check(busy, "R11 busy during sample", int'(busy), 1);
    wait_idle();
    check(last_len == 37, "R8 extended sample length", last_len, 37);
    check(nconv == base + 1 && log_chan[base] == 4'd11, "R12 conversion after sample", nconv - base, 1);

    // R10: abort with module-on cleared during a long sample
    wr(16, mkcfg(1, 1, 0, 1, 15, 4, 0, 0));
    base = nconv;
    soft_start();
    repeat (100) @(negedge clk);
    check(sample_hold, "R10 long sample running", int'(sample_hold), 1);
    wr(16, mkcfg(0, 1, 0, 1, 15, 4, 0, 0));
    repeat (3) @(negedge clk);
    check(!busy && !sample_hold, "R10 abort on module off", int'(busy), 0);
    repeat (20) @(negedge clk);
    check(nconv == base, "R10 abort writes nothing", nconv - base, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule